// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags of a serial-bus master controller and turns them into one level interrupt and two DMA request lines. The transfer logic reports events through one-cycle set pulses, one per flag; the flags stay set until software takes them through the vector register. The flags themselves cannot be written.

Software reaches the unit through a 16-bit register port. Reads return data in the same cycle. A read of the vector register reports the lowest-numbered pending enabled source as a 1-based index and clears only that flag on the clock edge that ends the read. Turning on a DMA channel hands the matching ready flag over to the DMA request line and drops its interrupt enable.

Register indices on `addr_i`: 0 revision, 1 interrupt enable, 2 status, 3 vector, 4 DMA configuration. Any other index reads as zero.

Top module: `ivu_top`

## Requirements
- R1: A status read (index 2) returns the stored flags at bits 1 (no-acknowledge), 2 (access-ready), 3 (receive-ready), 4 (transmit-ready), 9 (addressed-as-slave), 10 (transmit-underflow), 11 (receive-overrun) and 15 (single-byte-data). Bit 12 carries the live `bus_busy_i` level. Every other bit reads 0.
- R2: A one-cycle pulse on `set_i[k]` for a flag position k sets that flag from the next cycle on. The flag then stays set without further pulses.
- R3: The enable register (index 1) keeps only write-data bits 4:0 and reads back with all upper bits at 0.
- R4: `irq_o` is high exactly when some status bit in 4:0 is set together with the same enable bit.
- R5: A vector read (index 3) returns k+1, where k is the lowest set bit of (status[4:0] AND enable). After that cycle, flag k is cleared and all other flags are unchanged.
- R6: A vector read with nothing pending and enabled returns 0 and changes no flag.
- R7: The DMA register (index 4) keeps only write-data bit 15 (receive DMA enable) and bit 7 (transmit DMA enable).
- R8: A DMA write with bit 15 set clears enable bit 3. A DMA write with bit 7 set clears enable bit 4. Other enable bits are kept.
- R9: With receive DMA enabled, `rx_dma_req_o` equals status bit 3. With transmit DMA enabled, `tx_dma_req_o` equals status bit 4. Each request is 0 while its channel is disabled.
- R10: The revision register (index 0) reads 0x0011. Writes to indices 0, 2 and 3 change no state.
- R11: When a set pulse and a vector-read clear hit different flags in the same cycle, both take effect. When they hit the same flag, the flag stays set.
- R12: After reset, status, enable and DMA bits are 0, and `irq_o` and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the strobe cycle |
| set_i | input | 16 | Flag set pulses, one per status bit position |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Level interrupt |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is a vector-read clear and a set pulse landing in the same cycle, on the same flag and on different flags. The bench lines up exact cycles to create it. First it uses DMA writes and enable writes to leave exactly one source pending and enabled. Then it drives a set pulse in the same cycle as the vector read, once on a different flag and once on the flag the read takes. After each, the status register is read back to confirm the result.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int DW  = 16;
  localparam int IEW = 5;
  localparam int AW  = 3;

  typedef enum logic [AW-1:0] {
    REG_REV  = 3'd0,
    REG_IE   = 3'd1,
    REG_STAT = 3'd2,
    REG_VEC  = 3'd3,
    REG_DMA  = 3'd4
  } reg_sel_e;

  localparam logic [DW-1:0] FLAG_MASK = 16'h8E1E;
  localparam logic [DW-1:0] REV_VAL   = 16'h0011;
  localparam int BUSY_BIT  = 12;
  localparam int RRDY_BIT  = 3;
  localparam int XRDY_BIT  = 4;
  localparam int RXDMA_BIT = 15;
  localparam int TXDMA_BIT = 7;
endpackage

// File: rtl/ivu_flags.sv
module ivu_flags #(
  parameter int DW = 16,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q;

  // set has priority over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | (set_i & MASK);
  end

  assign stat_o = stat_q;

  // R2 R11
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & MASK) != '0) |=> ((stat_q & $past(set_i & MASK)) == $past(set_i & MASK)));

  // R5
  no_stray_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_i)) == '0));

  // R1
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~MASK) == '0);
endmodule

// File: rtl/ivu_cfg.sv
module ivu_cfg #(
  parameter int DW      = 16,
  parameter int IEW     = 5,
  parameter int RX_BIT  = 15,
  parameter int TX_BIT  = 7,
  parameter int RRDY    = 3,
  parameter int XRDY    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ie_we_i,
  input  logic           dma_we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [IEW-1:0] ie_o,
  output logic           rx_en_o,
  output logic           tx_en_o
);
  logic [IEW-1:0] ie_q;
  logic rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= '0;
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else if (ie_we_i) begin
      ie_q <= wdata_i[IEW-1:0];
    end else if (dma_we_i) begin
      rx_q <= wdata_i[RX_BIT];
      tx_q <= wdata_i[TX_BIT];
      // enabling a DMA channel takes its ready flag off the interrupt
      if (wdata_i[RX_BIT]) ie_q[RRDY] <= 1'b0;
      if (wdata_i[TX_BIT]) ie_q[XRDY] <= 1'b0;
    end
  end

  assign ie_o    = ie_q;
  assign rx_en_o = rx_q;
  assign tx_en_o = tx_q;

  // R8
  rx_dma_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_we_i && !ie_we_i && wdata_i[RX_BIT]) |=> !ie_q[RRDY]);

  // R8
  tx_dma_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_we_i && !ie_we_i && wdata_i[TX_BIT]) |=> !ie_q[XRDY]);
endmodule

// File: rtl/ivu_vector.sv
module ivu_vector #(
  parameter int IEW = 5,
  localparam int VW = $clog2(IEW + 1)
) (
  input  logic [IEW-1:0] pend_i,
  input  logic           ack_i,
  output logic [VW-1:0]  vec_o,
  output logic [IEW-1:0] clr_o
);
  logic [IEW-1:0] sel;

  // lowest set bit wins; scan from the top so the last hit is the lowest
  always_comb begin
    vec_o = '0;
    sel   = '0;
    for (int k = IEW - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        vec_o = VW'(k + 1);
        sel   = '0;
        sel[k] = 1'b1;
      end
    end
  end

  assign clr_o = ack_i ? sel : '0;
endmodule

// File: rtl/ivu_top.sv
module ivu_top
  import ivu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [DW-1:0]        set_i,
  input  logic                 bus_busy_i,
  output logic                 irq_o,
  output logic                 rx_dma_req_o,
  output logic                 tx_dma_req_o
);
  localparam int VW = $clog2(IEW + 1);

  logic [DW-1:0]  stat;
  logic [DW-1:0]  clr_full;
  logic [IEW-1:0] ie, pend, clr;
  logic [VW-1:0]  vec;
  logic           rx_en, tx_en, vec_ack;

  assign vec_ack  = rd_en_i && (addr_i == REG_VEC);
  assign pend     = stat[IEW-1:0] & ie;
  assign clr_full = {{(DW-IEW){1'b0}}, clr};

  ivu_flags #(.DW(DW), .MASK(FLAG_MASK)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_i),
    .clr_i (clr_full),
    .stat_o(stat)
  );

  ivu_cfg #(
    .DW(DW), .IEW(IEW), .RX_BIT(RXDMA_BIT), .TX_BIT(TXDMA_BIT),
    .RRDY(RRDY_BIT), .XRDY(XRDY_BIT)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ie_we_i (wr_en_i && (addr_i == REG_IE)),
    .dma_we_i(wr_en_i && (addr_i == REG_DMA)),
    .wdata_i (wdata_i),
    .ie_o    (ie),
    .rx_en_o (rx_en),
    .tx_en_o (tx_en)
  );

  ivu_vector #(.IEW(IEW)) u_vec (
    .pend_i(pend),
    .ack_i (vec_ack),
    .vec_o (vec),
    .clr_o (clr)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        REG_REV:  rdata_o = REV_VAL;
        REG_IE:   rdata_o = DW'(ie);
        REG_STAT: begin
          rdata_o = stat;
          rdata_o[BUSY_BIT] = bus_busy_i;
        end
        REG_VEC:  rdata_o = DW'(vec);
        REG_DMA:  begin
          rdata_o[RXDMA_BIT] = rx_en;
          rdata_o[TXDMA_BIT] = tx_en;
        end
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o        = |pend;
  assign rx_dma_req_o = rx_en & stat[RRDY_BIT];
  assign tx_dma_req_o = tx_en & stat[XRDY_BIT];

  // R4
  irq_vs_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec == '0) |-> !irq_o);

  // R9
  dma_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dma_req_o |-> rx_en) and (tx_dma_req_o |-> tx_en));
endmodule

// File: tb/tb_ivu_top.sv
`timescale 1ns/1ps
module tb_ivu_top;
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [15:0] data;  // write data or expected read data
    logic [15:0] set;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 33;
  localparam row_t TBL [NROWS] = '{
    '{2'd2, 3'd0, 16'h0011, 16'h0000, 4'd10}, // R10 revision
    '{2'd1, 3'd0, 16'hFFFF, 16'h0000, 4'd10},
    '{2'd2, 3'd0, 16'h0011, 16'h0000, 4'd10},
    '{2'd0, 3'd0, 16'h0000, 16'hFFFF, 4'd2},  // R2 pulse all
    '{2'd2, 3'd2, 16'h8E1E, 16'h0000, 4'd1},  // R1 layout
    '{2'd2, 3'd2, 16'h8E1E, 16'h0000, 4'd2},  // R2 sticky
    '{2'd1, 3'd2, 16'h0000, 16'h0000, 4'd10}, // R10 stat write
    '{2'd2, 3'd2, 16'h8E1E, 16'h0000, 4'd10},
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 4'd3},
    '{2'd2, 3'd3, 16'h0000, 16'h0000, 4'd6},  // R6 none enabled
    '{2'd2, 3'd2, 16'h8E1E, 16'h0000, 4'd6},
    '{2'd1, 3'd1, 16'hFFFF, 16'h0000, 4'd3},  // R3
    '{2'd2, 3'd1, 16'h001F, 16'h0000, 4'd3},
    '{2'd2, 3'd3, 16'h0002, 16'h0000, 4'd5},  // R5 bit1
    '{2'd2, 3'd2, 16'h8E1C, 16'h0000, 4'd5},
    '{2'd1, 3'd3, 16'h0000, 16'h0000, 4'd10}, // R10 vec write
    '{2'd2, 3'd2, 16'h8E1C, 16'h0000, 4'd10},
    '{2'd2, 3'd3, 16'h0003, 16'h0000, 4'd5},
    '{2'd2, 3'd3, 16'h0004, 16'h0000, 4'd5},
    '{2'd2, 3'd3, 16'h0005, 16'h0000, 4'd5},
    '{2'd2, 3'd3, 16'h0000, 16'h0000, 4'd6},
    '{2'd2, 3'd2, 16'h8E00, 16'h0000, 4'd5},
    '{2'd1, 3'd4, 16'hFFFF, 16'h0000, 4'd7},  // R7
    '{2'd2, 3'd4, 16'h8080, 16'h0000, 4'd7},
    '{2'd2, 3'd1, 16'h0007, 16'h0000, 4'd8},  // R8 both dropped
    '{2'd1, 3'd1, 16'h001F, 16'h0000, 4'd3},
    '{2'd1, 3'd4, 16'h0080, 16'h0000, 4'd8},
    '{2'd2, 3'd1, 16'h000F, 16'h0000, 4'd8},  // R8 only bit4 dropped
    '{2'd2, 3'd4, 16'h0080, 16'h0000, 4'd7},
    '{2'd2, 3'd7, 16'h0000, 16'h0000, 4'd1},  // unmapped
    '{2'd2, 3'd5, 16'h0000, 16'h0000, 4'd1},
    '{2'd2, 3'd6, 16'h0000, 16'h0000, 4'd1},
    '{2'd0, 3'd0, 16'h0000, 16'h0000, 4'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0, bus_busy_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, set_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, rx_dma_req_o, tx_dma_req_o;

  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk_i = ~clk_i;

  ivu_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .set_i(set_i),
    .bus_busy_i(bus_busy_i), .irq_o(irq_o), .rx_dma_req_o(rx_dma_req_o),
    .tx_dma_req_o(tx_dma_req_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, sample combinational read, clear after posedge
  task automatic cyc(input int op, input logic [2:0] a, input logic [15:0] d,
                     input logic [15:0] s, input string req);
    @(negedge clk_i);
    rd_en_i = (op == OP_RD);
    wr_en_i = (op == OP_WR);
    addr_i  = a;
    wdata_i = (op == OP_WR) ? d : 16'h0;
    set_i   = s;
    #1;
    if (op == OP_RD) check(req, rdata_o, d);
    @(posedge clk_i);
    #0.5;
    rd_en_i = 1'b0; wr_en_i = 1'b0; set_i = '0; wdata_i = '0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    // R12 reset state
    cyc(OP_RD, 3'd2, 16'h0000, 16'h0, "R12 stat");
    cyc(OP_RD, 3'd1, 16'h0000, 16'h0, "R12 ie");
    cyc(OP_RD, 3'd4, 16'h0000, 16'h0, "R12 dma");
    check("R12 outs", {13'h0, irq_o, rx_dma_req_o, tx_dma_req_o}, 16'h0);

    foreach (TBL[i])
      cyc(int'(TBL[i].op), TBL[i].addr, TBL[i].data, TBL[i].set,
          $sformatf("R%0d row %0d", TBL[i].req, i));

    // R1 live busy bit
    bus_busy_i = 1'b1;
    cyc(OP_RD, 3'd2, 16'h9E00, 16'h0, "R1 busy");
    bus_busy_i = 1'b0;

    // state: stat 0x8E00, ie 0x0F, tx dma on
    cyc(OP_IDLE, 3'd0, 16'h0, 16'h0010, "R9");
    #1;
    check("R9 tx req", {14'h0, rx_dma_req_o, tx_dma_req_o}, 16'h0001);
    check("R4 irq off", {15'h0, irq_o}, 16'h0);
    cyc(OP_WR, 3'd4, 16'h8000, 16'h0, "R8");
    #1;
    check("R9 tx off", {14'h0, rx_dma_req_o, tx_dma_req_o}, 16'h0000);
    cyc(OP_IDLE, 3'd0, 16'h0, 16'h0008, "R9");
    #1;
    check("R9 rx req", {14'h0, rx_dma_req_o, tx_dma_req_o}, 16'h0002);
    check("R4 irq masked", {15'h0, irq_o}, 16'h0);
    cyc(OP_RD, 3'd1, 16'h0007, 16'h0, "R8 ie");
    cyc(OP_IDLE, 3'd0, 16'h0, 16'h0004, "R4");
    #1;
    check("R4 irq on", {15'h0, irq_o}, 16'h1);

    // R11 set bit1 while the vector read takes bit2
    cyc(OP_RD, 3'd3, 16'h0003, 16'h0002, "R11 vec");
    cyc(OP_RD, 3'd2, 16'h8E1A, 16'h0, "R11 both");
    // R11 set and clear on the same flag
    cyc(OP_RD, 3'd3, 16'h0002, 16'h0002, "R11 same vec");
    cyc(OP_RD, 3'd2, 16'h8E1A, 16'h0, "R11 set wins");
    #1;
    check("R4 irq pending", {15'h0, irq_o}, 16'h1);

    // R12 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R12 outs after reset", {13'h0, irq_o, rx_dma_req_o, tx_dma_req_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(OP_RD, 3'd2, 16'h0000, 16'h0, "R12 stat cleared");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule